// File: doc/BRIEF.md
# Subblocked Write-Through Data Cache

A direct-mapped data cache in which every block holds several one-word subblocks. The subblocks of a block share one tag, and each subblock carries its own valid bit. The cache is write-through: every CPU write is forwarded to memory, and the CPU is acknowledged in the cycle the memory port accepts that write.

A write never waits for a fill. It stores the word, and on a tag mismatch it takes over the block for the new address, leaving only the written subblock valid. A read miss fetches only the addressed word from memory, not the whole block. That word is returned to the CPU and installed under the same tag rule.

The CPU holds a request, with its address, write flag and data, steady until `req_ready_o` goes high. Read data is valid in that same cycle. The memory port carries one transaction at a time. A request is offered with `mem_req_o` until `mem_gnt_i` accepts it, and read data comes back later on a `mem_rvalid_i` pulse.

Top module: `sbc_cache`

## Requirements
- R1: Reset (active-low `rst_ni`) clears every subblock valid bit, so the first read of any address after reset is a miss. During reset and in the idle state, `req_ready_o` and `mem_req_o` are low.
- R2: A read hits only when the stored tag matches and the addressed subblock is valid. A hit raises `req_ready_o` in the same cycle as the request, with the stored word, and issues no memory transaction.
- R3: A read miss issues exactly one memory read, whose word address equals the CPU address. The word returned on `mem_rvalid_i` goes to the CPU in that same cycle.
- R4: A read fill whose tag matches the stored tag sets only the filled subblock's valid bit and keeps the other subblocks valid.
- R5: Every CPU write issues exactly one memory write with the CPU's address and data, and issues no memory read.
- R6: A write is acknowledged in the cycle `mem_gnt_i` accepts it. With a grant delay of d cycles, `req_ready_o` is low for d+1 sampled cycles after the request appears. A pending memory request keeps its address stable.
- R7: A write that matches the tag of a valid subblock updates the word, and the subblock stays valid.
- R8: A write that matches the tag of an invalid subblock stores the word and sets that subblock valid.
- R9: A write with a tag mismatch stores the word, replaces the block tag, sets the written subblock valid and clears all other subblocks of the block.
- R10: A read fill with a tag mismatch replaces the tag, sets the filled subblock valid and clears the others.
- R11: At most one memory transaction is outstanding. After a read is granted, no new memory request is raised until its data returns.
- R12: The word address splits as offset = low log2(SUB_N) bits, index = next log2(BLK_N) bits, tag = remaining upper bits. Addresses that differ only in the tag share a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | CPU request present, held until ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | CPU word address |
| req_wdata_i | input | DATA_W | CPU write data |
| req_ready_o | output | 1 | Request completed this cycle |
| req_rdata_o | output | DATA_W | Read data, valid with req_ready_o on reads |
| mem_req_o | output | 1 | Memory transaction offered |
| mem_we_o | output | 1 | Memory transaction is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_gnt_i | input | 1 | Memory accepts the offered transaction |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The bench builds the cache with four subblocks and only four blocks, so index = address bits 3:2 and tag = bits 31:4. Addresses 0x20 and 0x30 then collide in block 0 after a few short requests. This exposes the conflict cases (write and fill tag takeover, invalidation of sibling subblocks, and write-through data coming back after eviction), and four blocks are few enough to cover every index. The memory model's grant delay and read latency are changed during the run, so the acknowledge timing of writes is measured at delays of 0, 1 and 3 cycles.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR      = 2'd1,
    ST_RD_REQ  = 2'd2,
    ST_RD_WAIT = 2'd3
  } sbc_state_e;
endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
  parameter int TAG_W = 26,
  parameter int IDX_W = 4,
  parameter int OFF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [OFF_W-1:0] lk_off_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [OFF_W-1:0] upd_off_i,
  input  logic [TAG_W-1:0] upd_tag_i
);
  localparam int BLK_N = 1 << IDX_W;
  localparam int SUB_N = 1 << OFF_W;

  logic [TAG_W-1:0] tag_q   [BLK_N];
  logic [SUB_N-1:0] valid_q [BLK_N];
  logic             upd_match;

  assign hit_o     = (tag_q[lk_idx_i] == lk_tag_i) && valid_q[lk_idx_i][lk_off_i];
  assign upd_match = (tag_q[upd_idx_i] == upd_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLK_N; b++) begin
        tag_q[b]   <= '0;
        valid_q[b] <= '0;
      end
    end else if (upd_en_i) begin
      if (upd_match) begin
        valid_q[upd_idx_i][upd_off_i] <= 1'b1;
      end else begin
        // tag takeover: only the touched word survives
        tag_q[upd_idx_i]   <= upd_tag_i;
        valid_q[upd_idx_i] <= SUB_N'(1) << upd_off_i;
      end
    end
  end
endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int BLK_N = 1 << IDX_W;
  localparam int SUB_N = 1 << OFF_W;

  logic [DATA_W-1:0] bank_rd [SUB_N];

  for (genvar s = 0; s < SUB_N; s++) begin : g_bank
    logic [DATA_W-1:0] word_q [BLK_N];
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_off_i == OFF_W'(s))) word_q[wr_idx_i] <= wr_data_i;
    end
    assign bank_rd[s] = word_q[rd_idx_i];
  end

  assign rd_data_o = bank_rd[rd_off_i];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  input  logic hit_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  output logic cap_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic ready_o,
  output logic upd_o,
  output logic fill_o
);
  sbc_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    cap_o     = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    ready_o   = 1'b0;
    upd_o     = 1'b0;
    fill_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_write_i) begin
            cap_o   = 1'b1;
            state_d = ST_WR;
          end else if (hit_i) begin
            ready_o = 1'b1;
          end else begin
            cap_o   = 1'b1;
            state_d = ST_RD_REQ;
          end
        end
      end
      ST_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_gnt_i) begin
          ready_o = 1'b1;
          upd_o   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RD_REQ: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        fill_o = 1'b1;
        if (mem_rvalid_i) begin
          ready_o = 1'b1;
          upd_o   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/sbc_cache.sv
module sbc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SUB_N  = 4,
  parameter int BLK_N  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int OFF_W = $clog2(SUB_N);
  localparam int IDX_W = $clog2(BLK_N);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap, upd, fill, hit;
  logic [DATA_W-1:0] arr_rdata, upd_data;

  wire [OFF_W-1:0] lk_off = req_addr_i[OFF_W-1:0];
  wire [IDX_W-1:0] lk_idx = req_addr_i[OFF_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] up_off = addr_q[OFF_W-1:0];
  wire [IDX_W-1:0] up_idx = addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0] up_tag = addr_q[ADDR_W-1 -: TAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  sbc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .hit_i       (hit),
    .mem_gnt_i   (mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i),
    .cap_o       (cap),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .ready_o     (req_ready_o),
    .upd_o       (upd),
    .fill_o      (fill)
  );

  sbc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lk_idx_i (lk_idx),
    .lk_off_i (lk_off),
    .lk_tag_i (lk_tag),
    .hit_o    (hit),
    .upd_en_i (upd),
    .upd_idx_i(up_idx),
    .upd_off_i(up_off),
    .upd_tag_i(up_tag)
  );

  assign upd_data = fill ? mem_rdata_i : wdata_q;

  sbc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
    .clk_i    (clk_i),
    .wr_en_i  (upd),
    .wr_idx_i (up_idx),
    .wr_off_i (up_off),
    .wr_data_i(upd_data),
    .rd_idx_i (lk_idx),
    .rd_off_i (lk_off),
    .rd_data_o(arr_rdata)
  );

  assign req_rdata_o = fill ? mem_rdata_i : arr_rdata;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_gnt_i
);
  AST_HIT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !req_write_i) |-> !mem_req_o); // R2

  AST_RD_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o == req_addr_i) && req_valid_i && !req_write_i); // R3

  AST_WR_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == req_addr_i) && (mem_wdata_o == req_wdata_i)); // R5

  AST_WR_ACK_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && req_write_i) |-> (mem_req_o && mem_we_o && mem_gnt_i)); // R6

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o))); // R6

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !mem_we_o) |=> !mem_req_o); // R11
endmodule

bind sbc_cache sbc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .req_ready_o(req_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_gnt_i  (mem_gnt_i)
);

// File: tb/tb_sbc_cache.sv
module tb_sbc_cache;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic [DW-1:0] req_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  sbc_cache #(.ADDR_W(AW), .DATA_W(DW), .SUB_N(4), .BLK_N(4)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .req_rdata_o(req_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return 32'hC0DE_0000 ^ (a * 32'h0000_9E37);
  endfunction

  // memory model
  logic [DW-1:0] mem_store [logic [AW-1:0]];
  logic [DW-1:0] ref_mem   [logic [AW-1:0]];
  int gnt_delay = 1, rd_lat = 1;
  int wcnt = 0, rd_pend = 0, mem_rd_seen = 0, mem_wr_seen = 0;
  logic [AW-1:0] rd_addr_l = '0;

  always @(posedge clk) begin
    #2;
    mem_gnt    = 1'b0;
    mem_rvalid = 1'b0;
    if (!rst_ni) begin
      wcnt = 0; rd_pend = 0;
    end else if (rd_pend > 0) begin
      rd_pend--;
      if (rd_pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_store.exists(rd_addr_l) ? mem_store[rd_addr_l] : init_val(rd_addr_l);
      end
    end else if (mem_req) begin
      if (wcnt < gnt_delay) wcnt++;
      else begin
        wcnt    = 0;
        mem_gnt = 1'b1;
        if (mem_we) begin
          mem_store[mem_addr] = mem_wdata;
          mem_wr_seen++;
        end else begin
          rd_addr_l = mem_addr;
          rd_pend   = rd_lat + 1;
          mem_rd_seen++;
        end
      end
    end
  end

  // scoreboard
  typedef struct {
    string         req;
    logic          is_read;
    logic [DW-1:0] data;
    int            n_rd;
    int            n_wr;
    int            wait_cyc;
  } exp_t;
  exp_t exp_q[$];
  int waits = 0, rd_base = 0, wr_base = 0;

  always @(negedge clk) begin
    if (rst_ni && req_valid && !req_ready) waits++;
    if (rst_ni && req_ready) begin
      if (exp_q.size() == 0) begin
        check("R2", "unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_read) check(e.req, "rdata", req_rdata, e.data);
        check(e.req, "mem reads", DW'(mem_rd_seen - rd_base), DW'(e.n_rd));
        check(e.req, "mem writes", DW'(mem_wr_seen - wr_base), DW'(e.n_wr));
        check(e.req, "wait cycles", DW'(waits), DW'(e.wait_cyc));
      end
      waits = 0;
      rd_base = mem_rd_seen;
      wr_base = mem_wr_seen;
    end
  end

  function automatic logic [DW-1:0] ref_val(input logic [AW-1:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : init_val(a);
  endfunction

  task automatic run_req();
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit miss, input string req);
    exp_t e;
    e.req = req; e.is_read = 1'b1; e.data = ref_val(a);
    e.n_rd = miss ? 1 : 0; e.n_wr = 0;
    e.wait_cyc = miss ? gnt_delay + 2 + rd_lat : 0;
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    run_req();
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    exp_t e;
    e.req = req; e.is_read = 1'b0; e.data = '0;
    e.n_rd = 0; e.n_wr = 1; e.wait_cyc = gnt_delay + 1;
    exp_q.push_back(e);
    ref_mem[a] = d;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    run_req();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "ready in reset", DW'(req_ready), 32'd0);
    check("R1", "mem_req in reset", DW'(mem_req), 32'd0);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "ready idle", DW'(req_ready), 32'd0);
    check("R1", "mem_req idle", DW'(mem_req), 32'd0);
    @(posedge clk); #1;

    // index = a[3:2], tag = a[31:4] (R12)
    do_read(32'h20, 1, "R1_R3");
    do_read(32'h20, 0, "R2");
    do_read(32'h21, 1, "R4");
    do_read(32'h20, 0, "R4");
    do_write(32'h22, 32'hAAAA_0001, "R5_R8");
    do_read(32'h22, 0, "R8");
    do_read(32'h21, 0, "R8");
    do_write(32'h20, 32'hBBBB_0002, "R7");
    do_read(32'h20, 0, "R7");
    do_write(32'h31, 32'hCCCC_0003, "R9_R12");
    do_read(32'h31, 0, "R9");
    do_read(32'h30, 1, "R9");
    do_read(32'h22, 1, "R9");
    do_read(32'h22, 0, "R10");
    do_read(32'h31, 1, "R10");
    do_read(32'h20, 1, "R10_R5");

    gnt_delay = 3; rd_lat = 2;
    do_write(32'h05, 32'hDDDD_0004, "R6_R8");
    do_read(32'h05, 0, "R6");
    do_read(32'h04, 1, "R11");
    do_read(32'h04, 0, "R4");

    gnt_delay = 0; rd_lat = 0;
    for (int i = 0; i < 4; i++) do_write(32'h40 + 32'(4 * i), 32'hE000_0000 + 32'(i), "R6_R12");
    for (int i = 0; i < 4; i++) do_read(32'h40 + 32'(4 * i), 0, "R12");
    do_read(32'h41, 1, "R4_R12");
    do_write(32'h41, 32'hF00D_0005, "R7");
    do_read(32'h41, 0, "R7");

    @(posedge clk); #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    do_read(32'h41, 1, "R1");
    do_read(32'h40, 1, "R1");

    repeat (3) @(posedge clk);
    check("R3", "scoreboard drained", DW'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule